// File: doc/BRIEF.md
# DMA Snoop Window Address Matcher

This block watches the addresses a DMA engine puts on its bus and decides, for each valid address, whether it lies inside one of two programmable snoop windows. A match raises a request for a cache-coherent transaction and reports which window matched. The coherent transaction, bus arbitration and any cache model are outside this block.

Each window is held in one 32-bit register. The register carries a 20-bit base address and a 5-bit size code. A legal code `c` (11 to 30) selects a window of 2^(c+1) bytes, from 4 KB up to 2 GB. Only the address bits at or above the window size are compared with the base. All other codes disable the window. Software writes and reads the two registers through a select bit, a write enable and a data port.

Top module: `snoop_window_match`

## Requirements
- R1: After reset both window registers read as zero, so both windows are disabled, and `snoop_req` and `snoop_win` are low.
- R2: With `cfg_we` high at a clock edge, the word on `cfg_wdata` is stored into the window chosen by `cfg_sel` (0 or 1). `cfg_rdata` shows the chosen window without delay. The base is in bits [31:12], the size code in bits [4:0], and bits [11:5] read as zero whatever was written there.
- R3: A window whose size code is 0 never matches, whatever the address.
- R4: Size codes 1 to 10 and code 31 also disable the window, so it never matches.
- R5: With a legal code c (11 to 30), a window matches when `dma_addr[31:c+1]` equals the same bits of `{base,12'h000}`. Base bits below bit c+1 have no effect on the result.
- R6: `snoop_req` is high in the cycle after a clock edge where `dma_valid` was high and at least one window matched. It is never high otherwise.
- R7: If both windows match, `snoop_win` is 0. `snoop_win` is 1 only when window 1 alone matched, and it is 0 whenever `snoop_req` is low.
- R8: Code 11 gives a 4 KB window that compares `dma_addr[31:12]`. Code 30 gives a 2 GB window that compares only `dma_addr[31]`.
- R9: Matching uses the register contents from before the clock edge, so a write in the same cycle takes effect for addresses in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 1 | Window register select for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Contents of the selected register |
| dma_valid | input | 1 | DMA address strobe |
| dma_addr | input | 32 | DMA byte address |
| snoop_req | output | 1 | Coherent-transaction request, one cycle after the address |
| snoop_win | output | 1 | Index of the matching window |

## Verification
The bench exercises the edges of the size code: 0, 1 to 10, 31, and the end values 11 and 30. A design with an off-by-one in the legal range would match on a window that should be disabled, or miss a window that should match. Addresses one byte below and one byte above a 4 KB window catch a mask that is shifted by one bit. A base with low bits set under a 2 MB window catches a design that compares bits it should ignore. Overlapping windows, a matching address with the strobe low, and a write in the same cycle as a lookup expose a wrong priority, a request raised without a valid address, or matching done against the new register value too early.

// File: rtl/snoop_window_match.sv
module snoop_window_match #(
  parameter int ADDR_W   = 32,
  parameter int BASE_W   = 20,
  parameter int CODE_W   = 5,
  parameter int MIN_CODE = 11,
  parameter int MAX_CODE = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              dma_valid,
  input  logic [ADDR_W-1:0] dma_addr,
  output logic              snoop_req,
  output logic              snoop_win
);
  localparam int LOW_W = ADDR_W - BASE_W;
  localparam int PAD_W = LOW_W - CODE_W;

  logic [BASE_W-1:0] base_q [2];
  logic [CODE_W-1:0] code_q [2];
  logic [1:0]        hit;
  logic              req_q, win_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < 2; w++) begin
        base_q[w] <= '0;
        code_q[w] <= '0;
      end
    end else if (cfg_we) begin
      base_q[cfg_sel] <= cfg_wdata[31 -: BASE_W];
      code_q[cfg_sel] <= cfg_wdata[CODE_W-1:0];
    end
  end

  assign cfg_rdata = {base_q[cfg_sel], {PAD_W{1'b0}}, code_q[cfg_sel]};

  for (genvar w = 0; w < 2; w++) begin : g_win
    logic              en;
    logic [CODE_W-1:0] shift;
    logic [BASE_W-1:0] mask;
    assign en     = (code_q[w] >= CODE_W'(MIN_CODE)) && (code_q[w] <= CODE_W'(MAX_CODE));
    assign shift  = code_q[w] - CODE_W'(MIN_CODE);
    assign mask   = {BASE_W{1'b1}} << shift;
    assign hit[w] = en && (((dma_addr[ADDR_W-1:LOW_W] ^ base_q[w]) & mask) == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      win_q <= 1'b0;
    end else begin
      req_q <= dma_valid && (hit != 2'b00);
      win_q <= dma_valid && !hit[0] && hit[1];
    end
  end

  assign snoop_req = req_q;
  assign snoop_win = win_q;

  AST_REQ_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_req |-> $past(dma_valid)); // R6
  AST_NO_VALID_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_valid |=> !snoop_req); // R6
  AST_WIN0_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && hit[0]) |=> (snoop_req && !snoop_win)); // R7
  AST_WIN1_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && !hit[0] && hit[1]) |=> (snoop_req && snoop_win)); // R7
  AST_WIN_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_win |-> snoop_req); // R7
  AST_ZERO_CODE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q[0] == '0 && code_q[1] == '0) |-> (hit == 2'b00)); // R3
endmodule

// File: tb/snoop_window_match_bench.sv
module snoop_window_match_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0, dma_valid = 1'b0;
  logic [31:0] cfg_wdata = '0, dma_addr = '0;
  logic [31:0] cfg_rdata;
  logic        snoop_req, snoop_win;

  always #4 clk = ~clk;

  snoop_window_match u_snoop_window_match (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dma_valid(dma_valid),
    .dma_addr(dma_addr), .snoop_req(snoop_req), .snoop_win(snoop_win)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  logic [19:0] mbase [2];
  logic [4:0]  mcode [2];
  bit    exp_req = 0, exp_win = 0;
  string prev_tag = "R1";

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit mhit(int w, logic [31:0] a);
    int c = mcode[w];
    longint unsigned sz, aa, bb;
    if (c < 11 || c > 30) return 0;
    sz = 64'd1 << (c + 1);
    aa = {32'd0, a};
    bb = {32'd0, mbase[w], 12'h000};
    return (aa / sz) == (bb / sz);
  endfunction

  task automatic step(string tag, bit we, bit sel, logic [31:0] wd, bit v, logic [31:0] a);
    bit h0, h1;
    @(negedge clk);
    check(prev_tag, "snoop_req", {31'd0, snoop_req}, {31'd0, exp_req});
    check(prev_tag, "snoop_win", {31'd0, snoop_win}, {31'd0, exp_win});
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd; dma_valid = v; dma_addr = a;
    h0 = mhit(0, a); h1 = mhit(1, a);
    exp_req = v && (h0 || h1);
    exp_win = v && !h0 && h1;
    prev_tag = tag;
    #1;
    check("R2", "cfg_rdata", cfg_rdata, {mbase[sel], 7'd0, mcode[sel]});
    @(posedge clk);
    if (we) begin
      mbase[sel] = wd[31:12];
      mcode[sel] = wd[4:0];
    end
  endtask

  task automatic wr(bit sel, logic [19:0] b, logic [4:0] c);
    step("R2", 1, sel, {b, 7'h7f, c}, 0, '0);
  endtask

  task automatic look(string tag, logic [31:0] a);
    step(tag, 0, 0, '0, 1, a);
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 2; w++) begin mbase[w] = '0; mcode[w] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    check("R1", "snoop_req", {31'd0, snoop_req}, 32'd0);
    check("R1", "snoop_win", {31'd0, snoop_win}, 32'd0);
    cfg_sel = 0; #1 check("R1", "rdata0", cfg_rdata, 32'd0);
    cfg_sel = 1; #1 check("R1", "rdata1", cfg_rdata, 32'd0);
    look("R1", 32'h0000_0000);
    // R3 code 0 disables
    wr(0, 20'h12345, 5'd0);
    look("R3", 32'h1234_5000);
    // R4 illegal codes
    wr(0, 20'h12345, 5'd1);
    look("R4", 32'h1234_5000);
    wr(0, 20'h12345, 5'd10);
    look("R4", 32'h1234_5000);
    wr(0, 20'h12345, 5'd31);
    look("R4", 32'h1234_5abc);
    // R8 4 KB window, R5 compare
    wr(0, 20'h12345, 5'd11);
    look("R8", 32'h1234_5abc);
    look("R8", 32'h1234_5000);
    look("R8", 32'h1234_5fff);
    look("R8", 32'h1234_6000);
    look("R8", 32'h1234_4fff);
    // R6 valid low with matching address
    step("R6", 0, 0, '0, 0, 32'h1234_5abc);
    // R5 2 MB window, low base bits ignored
    wr(0, 20'h12345, 5'd20);
    look("R5", 32'h1220_0000);
    look("R5", 32'h123f_ffff);
    look("R5", 32'h1240_0000);
    look("R5", 32'h121f_ffff);
    // R8 2 GB window on window 1 only
    wr(0, 20'h0, 5'd0);
    wr(1, 20'h80000, 5'd30);
    look("R7", 32'hffff_ffff);
    look("R8", 32'h8000_0000);
    look("R8", 32'h7fff_ffff);
    // R7 both match -> window 0
    wr(0, 20'hfffff, 5'd30);
    look("R7", 32'h9000_0000);
    look("R7", 32'h1000_0000);
    // R9 write in the same cycle as a lookup: old value used
    step("R9", 1, 0, {20'h00000, 7'd0, 5'd0}, 1, 32'h9000_0000);
    step("R9", 1, 1, {20'h00001, 7'd0, 5'd11}, 1, 32'h9000_0000);
    look("R9", 32'h0000_1800);
    look("R9", 32'h9000_0000);
    step("R6", 0, 0, '0, 0, '0);
    step("R6", 0, 1, '0, 0, '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule